// File: doc/BRIEF.md
# Serial Converter Single-Shot Read Sequencer

This block is the host side of a four-wire serial link to an external 10-bit successive-approximation converter. A one-cycle start request, together with a channel number, a unipolar/bipolar choice and a single-ended/differential choice, begins one read. The block builds a command byte and lowers chip select. It then runs three byte exchanges with the clock idling low. Data is launched on falling clock edges and captured on rising ones. The command byte goes out first, and two all-zero bytes follow. What comes back during the command byte is dropped. The conversion code is taken from the padded 16-bit word formed by the two later bytes.

The serial clock is the system clock divided by a runtime half-period value. That value is clamped so the link always runs between 100 kHz and 2 MHz, the limits being derived from a system-clock-frequency parameter. A programmable idle gap can be inserted between byte exchanges. A frame watchdog measures the time from the end of the command byte to the end of the last byte and flags the read when that time goes past 120 µs, because a held sample would have drooped by then. When the read finishes, the block raises chip select and pulses done. It presents the raw code, a sign-correct 11-bit value and the watchdog flag, and holds all of them until the next read completes.

Top module: `adc_conv_seq`

## Requirements
- R1: Each accepted start produces one frame: chip select goes low, 24 rising serial-clock edges follow, then chip select returns high. The first 8 bits sent, MSB first, are the command byte, and the remaining 16 bits are zero.
- R2: Command byte layout, MSB first: bit 7 = 1, bits 6..4 = channel number, bit 3 = 1 for unipolar and 0 for bipolar, bit 2 = 1 for single-ended and 0 for differential, bits 1..0 = 11. The serial clock idles low, the data line changes only while the clock is low, and the receive line is sampled on rising edges.
- R3: Each high phase and each low phase of the serial clock lasts D system cycles. D is the divider input clamped to the range [ceil(F/4 MHz), floor(F/200 kHz)], where F is the system clock frequency.
- R4: The code is bits 14..5 of the word {second received byte, third received byte}. The first received byte, bit 15, and bits 4..0 have no effect on it.
- R5: The signed output equals the code zero-extended in unipolar mode, and the code sign-extended (two's complement) in bipolar mode.
- R6: Done is high for exactly one cycle, in the cycle where chip select rises. The code, the signed value and the error flag change only in that cycle and hold afterwards.
- R7: A start request while a frame is in progress is ignored. It changes neither the frame in flight nor the idle state that follows it.
- R8: With an idle gap of G, chip select stays low for exactly 2·G system cycles longer than with a gap of zero, and the serial clock stays low during the gap.
- R9: The error flag reported with done is 1 when the cycles from the end of the command byte to the end of the last byte exceed F·120 µs, and 0 otherwise.
- R10: After reset, chip select is high, the serial clock and data line are low, busy and done are low, and the code, the signed value and the error flag are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | One-cycle read request |
| chan_i | input | 3 | Channel number for the command byte |
| bipolar_i | input | 1 | 1 = bipolar (two's complement) conversion |
| single_i | input | 1 | 1 = single-ended, 0 = differential input |
| div_i | input | DIV_W | Serial-clock half period in system cycles, before clamping |
| gap_i | input | GAP_W | Idle system cycles inserted between byte exchanges |
| busy_o | output | 1 | A frame is in progress |
| done_o | output | 1 | One-cycle completion pulse |
| result_o | output | 10 | Raw conversion code |
| value_o | output | 11 | Code extended according to the polarity mode |
| err_o | output | 1 | Frame exceeded the conversion time limit |
| cs_n_o | output | 1 | Active-low chip select to the converter |
| sclk_o | output | 1 | Serial clock to the converter |
| mosi_o | output | 1 | Serial data to the converter |
| miso_i | input | 1 | Serial data from the converter |

## Verification
A behavioural converter model answers every frame with a distinct code. The bench reads all 1024 codes through a bijective index map that also cycles through every channel, both polarities and both input modes, and it places varying junk in the discarded first byte and in the sub-LSB bits. This separates byte-ordering and bit-slicing mistakes from command-encoding mistakes. Divider values below, inside and above the legal window show whether clamping happens at each end. Pairs of frames that differ only in gap length isolate the gap timing. Gap lengths just inside and just outside the time limit show where the watchdog threshold sits, and the slowest clock shows that the limit trips even with no gap at all. A second start pulsed mid-frame shows that requests are ignored while busy.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    localparam int BYTE_W    = 8;
    localparam int CH_W      = 3;
    localparam int RES_W     = 10;
    localparam int SUB_W     = 2;
    localparam int TRAIL_W   = 3;
    localparam int RES_LSB   = SUB_W + TRAIL_W;
    localparam int NUM_BYTES = 3;
    localparam int IDX_W     = $clog2(NUM_BYTES);

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_XFER = 2'd1,
        ST_GAP  = 2'd2
    } seq_st_e;

    // command byte: start bit, channel, polarity, input mode, external-clock code
    function automatic logic [BYTE_W-1:0] build_ctrl(
        input logic [CH_W-1:0] ch,
        input logic            bip,
        input logic            sgl
    );
        return {1'b1, ch, ~bip, sgl, 2'b11};
    endfunction

endpackage

// File: rtl/adc_sclk_div.sv
module adc_sclk_div #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);

    logic [DIV_W-1:0] cnt_d, cnt_q;

    always_comb begin
        tick  = en && (cnt_q == div - DIV_W'(1));
        cnt_d = cnt_q + DIV_W'(1);
        if (!en || tick) begin
            cnt_d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

endmodule

// File: rtl/adc_spi_byte.sv
module adc_spi_byte
    import adc_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [BYTE_W-1:0] tx_byte,
    input  logic              tick,
    input  logic              miso,
    output logic              sclk,
    output logic              mosi,
    output logic              busy,
    output logic              done,
    output logic [BYTE_W-1:0] rx_byte
);

    localparam int BC_W = $clog2(BYTE_W);

    typedef struct packed {
        logic              run;
        logic              sclk;
        logic [BC_W-1:0]   bit_cnt;
        logic [BYTE_W-1:0] tx;
        logic [BYTE_W-1:0] rx;
        logic              done;
    } sh_t;

    sh_t sh_d, sh_q;

    always_comb begin
        sh_d      = sh_q;
        sh_d.done = 1'b0;
        if (load) begin
            sh_d.run     = 1'b1;
            sh_d.sclk    = 1'b0;
            sh_d.bit_cnt = '0;
            sh_d.tx      = tx_byte;
        end else if (sh_q.run && tick) begin
            if (!sh_q.sclk) begin
                // rising edge: capture the incoming bit
                sh_d.sclk = 1'b1;
                sh_d.rx   = {sh_q.rx[BYTE_W-2:0], miso};
            end else begin
                // falling edge: launch the next bit or finish
                sh_d.sclk = 1'b0;
                if (sh_q.bit_cnt == BC_W'(BYTE_W - 1)) begin
                    sh_d.run  = 1'b0;
                    sh_d.done = 1'b1;
                end else begin
                    sh_d.bit_cnt = sh_q.bit_cnt + BC_W'(1);
                    sh_d.tx      = {sh_q.tx[BYTE_W-2:0], 1'b0};
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q <= '0;
        end else begin
            sh_q <= sh_d;
        end
    end

    assign sclk    = sh_q.sclk;
    assign mosi    = sh_q.run & sh_q.tx[BYTE_W-1];
    assign busy    = sh_q.run;
    assign done    = sh_q.done;
    assign rx_byte = sh_q.rx;

endmodule

// File: rtl/adc_frame_wdog.sv
module adc_frame_wdog #(
    parameter int LIMIT = 480
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic run,
    output logic over
);

    localparam int LIM_W = $clog2(LIMIT + 2);

    logic [LIM_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clear) begin
            cnt_d = '0;
        end else if (run && (cnt_q <= LIM_W'(LIMIT))) begin
            cnt_d = cnt_q + LIM_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign over = (cnt_q > LIM_W'(LIMIT));

endmodule

// File: rtl/adc_conv_seq.sv
module adc_conv_seq
    import adc_seq_pkg::*;
#(
    parameter int SYS_CLK_HZ  = 50_000_000,
    parameter int SCLK_MIN_HZ = 100_000,
    parameter int SCLK_MAX_HZ = 2_000_000,
    parameter int TIMEOUT_US  = 120,
    parameter int DIV_W       = 8,
    parameter int GAP_W       = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [2:0]       chan_i,
    input  logic             bipolar_i,
    input  logic             single_i,
    input  logic [DIV_W-1:0] div_i,
    input  logic [GAP_W-1:0] gap_i,
    output logic             busy_o,
    output logic             done_o,
    output logic [9:0]       result_o,
    output logic [10:0]      value_o,
    output logic             err_o,
    output logic             cs_n_o,
    output logic             sclk_o,
    output logic             mosi_o,
    input  logic             miso_i
);

    localparam longint DIV_MIN_RAW =
        (longint'(SYS_CLK_HZ) + 2 * longint'(SCLK_MAX_HZ) - 1) / (2 * longint'(SCLK_MAX_HZ));
    localparam longint DIV_MAX_RAW = longint'(SYS_CLK_HZ) / (2 * longint'(SCLK_MIN_HZ));
    localparam int     DIV_MIN     = (DIV_MIN_RAW < 1) ? 1 : int'(DIV_MIN_RAW);
    localparam int     DIV_MAX     = (DIV_MAX_RAW < DIV_MIN_RAW) ? DIV_MIN : int'(DIV_MAX_RAW);
    localparam int     WD_LIMIT    =
        int'((longint'(SYS_CLK_HZ) * longint'(TIMEOUT_US)) / 64'd1_000_000);
    localparam int     RX1_W       = BYTE_W - 1;

    typedef struct packed {
        seq_st_e           st;
        logic              cs_n;
        logic              load;
        logic [BYTE_W-1:0] tx;
        logic [IDX_W-1:0]  idx;
        logic [DIV_W-1:0]  div;
        logic [GAP_W-1:0]  gap;
        logic [GAP_W-1:0]  gap_cnt;
        logic              bip;
        logic [RX1_W-1:0]  rx1;
        logic [RES_W-1:0]  result;
        logic [RES_W:0]    value;
        logic              err;
        logic              done;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic              tick;
    logic              sh_busy;
    logic              sh_done;
    logic [BYTE_W-1:0] sh_rx;
    logic              wd_over;
    logic [DIV_W-1:0]  div_eff;
    logic [RES_W-1:0]  code;

    // keep the serial clock inside the legal window
    always_comb begin
        div_eff = div_i;
        if (div_i < DIV_W'(DIV_MIN)) begin
            div_eff = DIV_W'(DIV_MIN);
        end else if (div_i > DIV_W'(DIV_MAX)) begin
            div_eff = DIV_W'(DIV_MAX);
        end
    end

    // padded word {rx1, rx2}: one lead zero, code, sub-LSBs, trailing zeros
    assign code = {ctl_q.rx1, sh_rx[BYTE_W-1:RES_LSB]};

    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.load = 1'b0;
        ctl_d.done = 1'b0;
        unique case (ctl_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    ctl_d.st   = ST_XFER;
                    ctl_d.cs_n = 1'b0;
                    ctl_d.load = 1'b1;
                    ctl_d.tx   = build_ctrl(chan_i, bipolar_i, single_i);
                    ctl_d.idx  = '0;
                    ctl_d.div  = div_eff;
                    ctl_d.gap  = gap_i;
                    ctl_d.bip  = bipolar_i;
                end
            end
            ST_XFER: begin
                if (sh_done) begin
                    if (ctl_q.idx == IDX_W'(NUM_BYTES - 1)) begin
                        ctl_d.st     = ST_IDLE;
                        ctl_d.cs_n   = 1'b1;
                        ctl_d.done   = 1'b1;
                        ctl_d.result = code;
                        ctl_d.value  = ctl_q.bip ? {code[RES_W-1], code} : {1'b0, code};
                        ctl_d.err    = wd_over;
                    end else begin
                        if (ctl_q.idx == IDX_W'(1)) begin
                            ctl_d.rx1 = sh_rx[RX1_W-1:0];
                        end
                        ctl_d.idx = ctl_q.idx + IDX_W'(1);
                        ctl_d.tx  = '0;
                        if (ctl_q.gap == '0) begin
                            ctl_d.load = 1'b1;
                        end else begin
                            ctl_d.st      = ST_GAP;
                            ctl_d.gap_cnt = ctl_q.gap;
                        end
                    end
                end
            end
            ST_GAP: begin
                ctl_d.gap_cnt = ctl_q.gap_cnt - GAP_W'(1);
                if (ctl_q.gap_cnt == GAP_W'(1)) begin
                    ctl_d.st   = ST_XFER;
                    ctl_d.load = 1'b1;
                end
            end
            default: begin
                ctl_d.st   = ST_IDLE;
                ctl_d.cs_n = 1'b1;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q      <= '0;
            ctl_q.cs_n <= 1'b1;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    adc_sclk_div #(
        .DIV_W (DIV_W)
    ) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (sh_busy),
        .div   (ctl_q.div),
        .tick  (tick)
    );

    adc_spi_byte u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (ctl_q.load),
        .tx_byte (ctl_q.tx),
        .tick    (tick),
        .miso    (miso_i),
        .sclk    (sclk_o),
        .mosi    (mosi_o),
        .busy    (sh_busy),
        .done    (sh_done),
        .rx_byte (sh_rx)
    );

    adc_frame_wdog #(
        .LIMIT (WD_LIMIT)
    ) u_wdog (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (ctl_q.st == ST_IDLE),
        .run   ((ctl_q.st != ST_IDLE) && (ctl_q.idx != '0)),
        .over  (wd_over)
    );

    assign busy_o   = (ctl_q.st != ST_IDLE);
    assign done_o   = ctl_q.done;
    assign result_o = ctl_q.result;
    assign value_o  = ctl_q.value;
    assign err_o    = ctl_q.err;
    assign cs_n_o   = ctl_q.cs_n;

endmodule

// File: rtl/adc_conv_seq_chk.sv
module adc_conv_seq_chk #(
    parameter int DIV_MIN = 1,
    parameter int DIV_MAX = 250
) (
    input logic       clk,
    input logic       rst_n,
    input logic       cs_n_o,
    input logic       sclk_o,
    input logic       mosi_o,
    input logic       done_o,
    input logic       busy_o,
    input logic [9:0] result_o,
    input logic       err_o
);

    logic [15:0] hi_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_q <= '0;
        end else begin
            hi_q <= sclk_o ? hi_q + 16'd1 : 16'd0;
        end
    end

    a_r2_clk_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n_o |-> !sclk_o);

    a_r2_data_stable_high: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk_o && $past(sclk_o)) |-> $stable(mosi_o));

    a_r3_half_period: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sclk_o) |-> (hi_q >= 16'(DIV_MIN) && hi_q <= 16'(DIV_MAX)));

    a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    a_r6_done_with_cs_rise: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> $rose(cs_n_o));

    a_r6_result_held: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> $stable(result_o));

    a_r9_err_at_done: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> $stable(err_o));

    a_r7_busy_covers_frame: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_n_o |-> busy_o);

endmodule

bind adc_conv_seq adc_conv_seq_chk #(
    .DIV_MIN (DIV_MIN),
    .DIV_MAX (DIV_MAX)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cs_n_o   (cs_n_o),
    .sclk_o   (sclk_o),
    .mosi_o   (mosi_o),
    .done_o   (done_o),
    .busy_o   (busy_o),
    .result_o (result_o),
    .err_o    (err_o)
);

// File: tb/tb_adc_conv_seq.sv
module tb_adc_conv_seq;

    localparam int SYS = 4_000_000;   // clamp window [1,20], limit 480 cycles

    logic        clk = 1'b0;
    logic        rst_n;
    logic        start_i;
    logic [2:0]  chan_i;
    logic        bipolar_i;
    logic        single_i;
    logic [7:0]  div_i;
    logic [7:0]  gap_i;
    logic        busy_o, done_o, err_o, cs_n_o, sclk_o, mosi_o;
    logic [9:0]  result_o;
    logic [10:0] value_o;
    logic        miso_i = 1'b0;

    always #2 clk = ~clk;

    adc_conv_seq #(
        .SYS_CLK_HZ (SYS),
        .DIV_W      (8),
        .GAP_W      (8)
    ) dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start_i),
        .chan_i    (chan_i),
        .bipolar_i (bipolar_i),
        .single_i  (single_i),
        .div_i     (div_i),
        .gap_i     (gap_i),
        .busy_o    (busy_o),
        .done_o    (done_o),
        .result_o  (result_o),
        .value_o   (value_o),
        .err_o     (err_o),
        .cs_n_o    (cs_n_o),
        .sclk_o    (sclk_o),
        .mosi_o    (mosi_o),
        .miso_i    (miso_i)
    );

    int checks = 0;
    int errors = 0;

    // converter model, evaluated away from the active edge
    logic [23:0] adc_word = '0;
    logic [23:0] m_mosi   = '0;
    int          m_rise   = 0;
    int          m_idx    = 0;
    int          hi_run   = 0;
    int          hw_first = 0;
    logic        p_cs     = 1'b1;
    logic        p_sclk   = 1'b0;

    always @(negedge clk) begin
        if (p_cs && !cs_n_o) begin
            m_idx    = 0;
            m_rise   = 0;
            m_mosi   = '0;
            hw_first = 0;
            hi_run   = 0;
        end else if (!cs_n_o) begin
            if (!p_sclk && sclk_o) begin
                m_mosi = {m_mosi[22:0], mosi_o};
                m_rise++;
            end
            if (p_sclk && !sclk_o) begin
                m_idx++;
                if (hw_first == 0) hw_first = hi_run;
                hi_run = 0;
            end
            if (sclk_o) hi_run++;
        end
        miso_i = (m_idx < 24) ? adc_word[23 - m_idx] : 1'b0;
        p_cs   = cs_n_o;
        p_sclk = sclk_o;
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic finish_sim();
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual hung expected finished");
        finish_sim();
    end

    function automatic int exp_value(input logic [9:0] c, input logic bip);
        logic [10:0] v;
        v = bip ? {c[9], c} : {1'b0, c};
        return int'(v);
    endfunction

    int cs_len;

    task automatic run_frame(input logic [2:0] ch, input logic bip, input logic sgl,
                             input int div, input int gap, input logic [9:0] code,
                             input logic [1:0] sub, input logic [7:0] first,
                             input int poke);
        int n;
        adc_word  = {first, 1'b0, code, sub, 3'b000};
        chan_i    = ch;
        bipolar_i = bip;
        single_i  = sgl;
        div_i     = 8'(div);
        gap_i     = 8'(gap);
        start_i   = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        n       = 0;
        cs_len  = 0;
        while (!done_o && n < 4000) begin
            if (!cs_n_o) cs_len++;
            if (n == poke) begin
                start_i = 1'b1;
                chan_i  = ~ch;
            end else begin
                start_i = 1'b0;
            end
            @(negedge clk);
            n++;
        end
        start_i = 1'b0;
        chk("R6", "done observed", int'(done_o), 1);
    endtask

    task automatic check_frame(input logic [2:0] ch, input logic bip, input logic sgl,
                               input logic [9:0] code);
        logic [7:0] ctrl;
        ctrl = {1'b1, ch, ~bip, sgl, 2'b11};
        chk("R2", "command byte", int'(m_mosi[23:16]), int'(ctrl));
        chk("R1", "zero tail bytes", int'(m_mosi[15:0]), 0);
        chk("R1", "rising edges", m_rise, 24);
        chk("R4", "code", int'(result_o), int'(code));
        chk("R5", "signed value", int'(value_o), exp_value(code, bip));
    endtask

    initial begin
        int len0;
        logic [9:0] held;
        rst_n     = 1'b0;
        start_i   = 1'b0;
        chan_i    = '0;
        bipolar_i = 1'b0;
        single_i  = 1'b0;
        div_i     = 8'd1;
        gap_i     = 8'd0;
        repeat (4) @(negedge clk);
        chk("R10", "cs_n", int'(cs_n_o), 1);
        chk("R10", "sclk", int'(sclk_o), 0);
        chk("R10", "mosi", int'(mosi_o), 0);
        chk("R10", "busy", int'(busy_o), 0);
        chk("R10", "done", int'(done_o), 0);
        chk("R10", "result", int'(result_o), 0);
        chk("R10", "value", int'(value_o), 0);
        chk("R10", "err", int'(err_o), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // every code once, cycling channel, polarity and input mode
        for (int i = 0; i < 1024; i++) begin
            logic [9:0] c;
            c = 10'((i * 389 + 5) % 1024);
            run_frame(3'(i % 8), 1'((i / 8) % 2), 1'((i / 16) % 2), 1, 0, c,
                      2'(i % 4), 8'((i * 7 + 1) % 256), -1);
            check_frame(3'(i % 8), 1'((i / 8) % 2), 1'((i / 16) % 2), c);
            chk("R9", "no timeout at fast clock", int'(err_o), 0);
            @(negedge clk);
        end

        // R3 clamping and half period
        run_frame(3'd2, 1'b0, 1'b1, 0, 0, 10'd300, 2'd1, 8'hFF, -1);
        chk("R3", "half period, divider 0", hw_first, 1);
        check_frame(3'd2, 1'b0, 1'b1, 10'd300);
        run_frame(3'd5, 1'b1, 1'b0, 7, 0, 10'd512, 2'd3, 8'h80, -1);
        chk("R3", "half period, divider 7", hw_first, 7);
        check_frame(3'd5, 1'b1, 1'b0, 10'd512);
        chk("R9", "224 cycles within limit", int'(err_o), 0);
        run_frame(3'd7, 1'b1, 1'b1, 200, 0, 10'd1023, 2'd2, 8'h55, -1);
        chk("R3", "half period, divider 200", hw_first, 20);
        check_frame(3'd7, 1'b1, 1'b1, 10'd1023);
        chk("R9", "slowest clock exceeds limit", int'(err_o), 1);

        // R8 gap length
        run_frame(3'd1, 1'b0, 1'b0, 2, 0, 10'd77, 2'd0, 8'h00, -1);
        len0 = cs_len;
        run_frame(3'd1, 1'b0, 1'b0, 2, 30, 10'd77, 2'd0, 8'h00, -1);
        chk("R8", "frame growth for gap 30", cs_len - len0, 60);
        check_frame(3'd1, 1'b0, 1'b0, 10'd77);

        // R9 threshold around the limit
        run_frame(3'd3, 1'b1, 1'b0, 1, 200, 10'd600, 2'd1, 8'h11, -1);
        chk("R9", "gap 200 inside limit", int'(err_o), 0);
        run_frame(3'd3, 1'b1, 1'b0, 1, 250, 10'd600, 2'd1, 8'h11, -1);
        chk("R9", "gap 250 over limit", int'(err_o), 1);
        check_frame(3'd3, 1'b1, 1'b0, 10'd600);

        // R7 start while busy, R6 pulse width and hold
        run_frame(3'd3, 1'b0, 1'b1, 4, 0, 10'd401, 2'd2, 8'hC3, 20);
        check_frame(3'd3, 1'b0, 1'b1, 10'd401);
        chk("R9", "no timeout", int'(err_o), 0);
        held = result_o;
        @(negedge clk);
        chk("R6", "done low after one cycle", int'(done_o), 0);
        begin
            int lows = 0;
            for (int k = 0; k < 40; k++) begin
                if (!cs_n_o || busy_o) lows++;
                @(negedge clk);
            end
            chk("R7", "no frame from ignored start", lows, 0);
        end
        chk("R6", "code held after done", int'(result_o), int'(held));
        chk("R7", "rising edges of frame", m_rise, 24);

        finish_sim();
    end

endmodule